// File: doc/BRIEF.md
# Two-Wire Debug Host Transaction Engine

This block is the host end of a two-wire debug link: one generated clock line and one bidirectional data line. A command is one transaction. It names the target port (debug port or access port), the direction, a 2-bit register address and, for writes, 32 bits of data. The command enters through a valid/ready handshake. The engine then frames an 8-bit request, hands the line to the target for one turnaround slot and reads a 3-bit acknowledge. What follows depends on that code: a data phase in the proper direction, or a turnaround that ends the transaction.

Each transaction produces one response pulse. The pulse carries the raw acknowledge, any read data, a read-parity-error flag and a flag for an acknowledge outside the defined codes. The data line is split into a drive value, a drive enable and a sampled input, so the pad or a test model can resolve it. A programmable divider sets the rate of the generated clock. Between transactions the engine keeps the clock running and holds the line low for a minimum number of idle slots.

Top module: `dwire_host`

## Requirements
- R1: The request is shifted out least-significant bit first in this order: bit 0 = 1 (start), bit 1 = port select (1 = access port), bit 2 = direction (1 = read), bit 3 = address bit 0, bit 4 = address bit 1, bit 5 = XOR of bits 1 to 4, bit 6 = 0, bit 7 = 1 (driven by the host).
- R2: `wclk` toggles every `div_i`+1 system clocks. `dio_o` and `dio_oe` change only on the system clock edge where `wclk` falls, and `dio_i` is taken at the rising edges of `wclk`.
- R3: After the request the line is released (`dio_oe`=0) for one slot. The acknowledge is then sampled over three released slots, and the first bit received lands in `rsp_ack[0]`. The codes are: 3'b001 = OK, 3'b010 = WAIT, 3'b100 = FAULT.
- R4: On a write acknowledged OK, 32 data bits (LSB first) and then their XOR parity bit are driven in the slots right after the acknowledge. The line is driven low in the very next slot, with no turnaround.
- R5: On a read acknowledged OK, 33 slots are sampled with the line released: 32 data bits LSB first, then a parity bit. One turnaround slot follows, and the data is returned on `rsp_rdata`.
- R6: `rsp_perr` is 1 only for a read acknowledged OK whose received parity bit differs from the XOR of the 32 received data bits.
- R7: After WAIT or FAULT there is exactly one turnaround slot, then the line goes back to idle. No data phase takes place and `rsp_rdata` is 0.
- R8: Any acknowledge other than the three codes sets `rsp_proto_err` and is handled like R7, with `rsp_perr` at 0.
- R9: After reset and after every transaction, the line is driven low. `cmd_ready` rises only after two falling edges of `wclk` have passed in the idle state, and it drops after a command is accepted.
- R10: Every accepted command yields exactly one `rsp_valid` pulse, one system clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | Half-period of `wclk` in system clocks, minus one |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle and ready to take a command |
| cmd_ap | input | 1 | 1 = access port, 0 = debug port |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | 2 | Register address bits [3:2] |
| cmd_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_ack | output | 3 | Received acknowledge, first bit in bit 0 |
| rsp_rdata | output | DATA_W | Read data, zero unless read with OK |
| rsp_perr | output | 1 | Read parity mismatch |
| rsp_proto_err | output | 1 | Acknowledge not one of the defined codes |
| wclk | output | 1 | Generated link clock |
| dio_o | output | 1 | Data line drive value |
| dio_oe | output | 1 | Data line drive enable |
| dio_i | input | 1 | Data line sampled value |

## Verification
The vector walk covers writes and reads to both port kinds and to all four addresses, so every request bit pattern, including both parity values, appears on the line. The acknowledge inputs are OK, WAIT, FAULT and an all-ones undefined code. These separate the three endings: write data with no turnaround, read data followed by a turnaround, and turnaround only. Read data patterns with correct and with corrupted parity, plus an all-zero word, show whether `rsp_perr` follows the received bit or the data. The directed tests count idle falling edges after reset and measure the `wclk` half period at two divider settings.

// File: rtl/dwh_pkg.sv
`timescale 1ns/1ps
package dwh_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARM,
      ST_HDR,
      ST_TRN_A,
      ST_ACK,
      ST_WDAT,
      ST_RDAT,
      ST_TRN_B
   } dwh_state_e;

   localparam logic [2:0] ACK_OK    = 3'b001;
   localparam logic [2:0] ACK_WAIT  = 3'b010;
   localparam logic [2:0] ACK_FAULT = 3'b100;

   localparam int HDR_BITS = 8;

   // request frame, index 0 leaves first
   function automatic logic [HDR_BITS-1:0] make_hdr(input logic ap,
                                                    input logic rd,
                                                    input logic [1:0] addr);
      logic par;
      par = ap ^ rd ^ addr[0] ^ addr[1];
      return {1'b1, 1'b0, par, addr[1], addr[0], rd, ap, 1'b1};
   endfunction

   function automatic logic ack_known(input logic [2:0] a);
      return (a == ACK_OK) || (a == ACK_WAIT) || (a == ACK_FAULT);
   endfunction

endpackage

// File: rtl/dwh_clkgen.sv
`timescale 1ns/1ps
module dwh_clkgen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_i,
   output logic             wclk_o,
   output logic             fall_o,
   output logic             rise_o
);

   logic [DIV_W-1:0] cnt;
   logic             hit;

   // >= so that lowering div_i mid-count never skips a wrap
   assign hit    = (cnt >= div_i);
   assign fall_o = hit &&  wclk_o;
   assign rise_o = hit && !wclk_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         wclk_o <= 1'b0;
      end else if (hit) begin
         cnt    <= '0;
         wclk_o <= ~wclk_o;
      end else begin
         cnt    <= cnt + DIV_W'(1);
      end
   end

endmodule

// File: rtl/dwh_rx.sv
`timescale 1ns/1ps
module dwh_rx #(
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2,
   parameter int CW          = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dio_i,
   input  logic              clr,
   input  logic              cap_ack,
   input  logic              cap_dat,
   input  logic [CW-1:0]     idx,
   output logic [2:0]        ack_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              par_err_o
);

   logic smp;
   logic par_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign smp = dio_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '1;
            end else begin
               for (int k = SYNC_STAGES - 1; k > 0; k--) begin
                  chain[k] <= chain[k-1];
               end
               chain[0] <= dio_i;
            end
         end
         assign smp = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_o   <= '0;
         rdata_o <= '0;
         par_q   <= 1'b0;
      end else if (clr) begin
         ack_o   <= '0;
         rdata_o <= '0;
         par_q   <= 1'b0;
      end else begin
         if (cap_ack) begin
            ack_o[idx[1:0]] <= smp;
         end
         if (cap_dat) begin
            if (idx < CW'(DATA_W)) begin
               rdata_o <= {smp, rdata_o[DATA_W-1:1]};
            end else begin
               par_q <= smp;
            end
         end
      end
   end

   assign par_err_o = (^rdata_o) ^ par_q;

endmodule

// File: rtl/dwh_tx.sv
`timescale 1ns/1ps
module dwh_tx #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_hdr,
   input  logic [7:0]        hdr,
   input  logic              load_dat,
   input  logic [DATA_W-1:0] wdata,
   input  logic              step,
   input  logic              zero,
   output logic              dio_o
);

   localparam int SW = DATA_W + 1;

   logic [SW-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dio_o <= 1'b0;
         sh    <= '0;
      end else if (load_hdr) begin
         dio_o <= hdr[0];
         sh    <= SW'(hdr[7:1]);
      end else if (load_dat) begin
         dio_o <= wdata[0];
         sh    <= SW'({^wdata, wdata[DATA_W-1:1]});
      end else if (step) begin
         dio_o <= sh[0];
         sh    <= sh >> 1;
      end else if (zero) begin
         dio_o <= 1'b0;
      end
   end

endmodule

// File: rtl/dwire_host.sv
`timescale 1ns/1ps
module dwire_host
   import dwh_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int DIV_W       = 8,
   parameter int IDLE_MIN    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  div_i,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_ap,
   input  logic              cmd_rd,
   input  logic [1:0]        cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              rsp_valid,
   output logic [2:0]        rsp_ack,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_perr,
   output logic              rsp_proto_err,
   output logic              wclk,
   output logic              dio_o,
   output logic              dio_oe,
   input  logic              dio_i
);

   localparam int CW = $clog2(DATA_W + 1);
   localparam int IW = $clog2(IDLE_MIN + 1);

   generate
      if (DATA_W < 8) begin : g_bad_data_w
         $error("dwire_host: DATA_W must be at least 8");
      end
      if (DIV_W < 1) begin : g_bad_div_w
         $error("dwire_host: DIV_W must be at least 1");
      end
      if (IDLE_MIN < 1) begin : g_bad_idle
         $error("dwire_host: IDLE_MIN must be at least 1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("dwire_host: SYNC_STAGES cannot be negative");
      end
   endgenerate

   dwh_state_e        st;
   logic [CW-1:0]     bcnt;
   logic [IW-1:0]     idle_cnt;
   logic              oe_q;
   logic              c_ap;
   logic              c_rd;
   logic [1:0]        c_addr;
   logic [DATA_W-1:0] c_wdata;

   logic              fall_ev;
   logic              rise_ev;
   logic [2:0]        ack;
   logic [DATA_W-1:0] rdata;
   logic              par_err;
   logic [7:0]        hdr;
   logic              ack_ok;
   logic              hdr_last;
   logic              ack_last;
   logic              dat_last;
   logic              accept;
   logic              fin;
   logic              tx_load_hdr;
   logic              tx_load_dat;
   logic              tx_step;
   logic              tx_zero;
   logic              rx_cap_ack;
   logic              rx_cap_dat;

   dwh_clkgen #(
      .DIV_W (DIV_W)
   ) i_clkgen (
      .clk    (clk),
      .rst_n  (rst_n),
      .div_i  (div_i),
      .wclk_o (wclk),
      .fall_o (fall_ev),
      .rise_o (rise_ev)
   );

   assign hdr      = make_hdr(c_ap, c_rd, c_addr);
   assign ack_ok   = (ack == ACK_OK);
   assign hdr_last = (bcnt == CW'(HDR_BITS - 1));
   assign ack_last = (bcnt == CW'(2));
   assign dat_last = (bcnt == CW'(DATA_W));
   assign cmd_ready = (st == ST_IDLE) && (idle_cnt == IW'(IDLE_MIN));
   assign accept   = cmd_valid && cmd_ready;

   assign fin         = fall_ev && ((st == ST_WDAT && dat_last) || st == ST_TRN_B);
   assign tx_load_hdr = fall_ev && (st == ST_ARM);
   assign tx_load_dat = fall_ev && (st == ST_ACK) && ack_last && ack_ok && !c_rd;
   assign tx_step     = fall_ev && ((st == ST_HDR && !hdr_last) ||
                                    (st == ST_WDAT && !dat_last));
   assign tx_zero     = fin || (fall_ev && st == ST_IDLE);
   assign rx_cap_ack  = rise_ev && (st == ST_ACK);
   assign rx_cap_dat  = rise_ev && (st == ST_RDAT);

   dwh_tx #(
      .DATA_W (DATA_W)
   ) i_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_hdr (tx_load_hdr),
      .hdr      (hdr),
      .load_dat (tx_load_dat),
      .wdata    (c_wdata),
      .step     (tx_step),
      .zero     (tx_zero),
      .dio_o    (dio_o)
   );

   dwh_rx #(
      .DATA_W      (DATA_W),
      .SYNC_STAGES (SYNC_STAGES),
      .CW          (CW)
   ) i_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .dio_i     (dio_i),
      .clr       (accept),
      .cap_ack   (rx_cap_ack),
      .cap_dat   (rx_cap_dat),
      .idx       (bcnt),
      .ack_o     (ack),
      .rdata_o   (rdata),
      .par_err_o (par_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st            <= ST_IDLE;
         bcnt          <= '0;
         idle_cnt      <= '0;
         oe_q          <= 1'b1;
         c_ap          <= 1'b0;
         c_rd          <= 1'b0;
         c_addr        <= '0;
         c_wdata       <= '0;
         rsp_valid     <= 1'b0;
         rsp_ack       <= '0;
         rsp_rdata     <= '0;
         rsp_perr      <= 1'b0;
         rsp_proto_err <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         if (accept) begin
            st       <= ST_ARM;
            idle_cnt <= '0;
            c_ap     <= cmd_ap;
            c_rd     <= cmd_rd;
            c_addr   <= cmd_addr;
            c_wdata  <= cmd_wdata;
         end else if (fin) begin
            st            <= ST_IDLE;
            oe_q          <= 1'b1;
            idle_cnt      <= '0;
            rsp_valid     <= 1'b1;
            rsp_ack       <= ack;
            rsp_proto_err <= !ack_known(ack);
            rsp_perr      <= c_rd && ack_ok && par_err;
            rsp_rdata     <= (c_rd && ack_ok) ? rdata : '0;
         end else if (fall_ev) begin
            unique case (st)
               ST_IDLE: begin
                  if (idle_cnt != IW'(IDLE_MIN)) begin
                     idle_cnt <= idle_cnt + IW'(1);
                  end
               end
               ST_ARM: begin
                  st   <= ST_HDR;
                  bcnt <= '0;
                  oe_q <= 1'b1;
               end
               ST_HDR: begin
                  if (hdr_last) begin
                     st   <= ST_TRN_A;
                     oe_q <= 1'b0;
                  end else begin
                     bcnt <= bcnt + CW'(1);
                  end
               end
               ST_TRN_A: begin
                  st   <= ST_ACK;
                  bcnt <= '0;
               end
               ST_ACK: begin
                  if (!ack_last) begin
                     bcnt <= bcnt + CW'(1);
                  end else if (ack_ok) begin
                     bcnt <= '0;
                     if (c_rd) begin
                        st <= ST_RDAT;
                     end else begin
                        st   <= ST_WDAT;
                        oe_q <= 1'b1;
                     end
                  end else begin
                     st <= ST_TRN_B;
                  end
               end
               ST_WDAT: begin
                  bcnt <= bcnt + CW'(1);
               end
               ST_RDAT: begin
                  if (dat_last) begin
                     st <= ST_TRN_B;
                  end else begin
                     bcnt <= bcnt + CW'(1);
                  end
               end
               ST_TRN_B: begin
                  st <= ST_IDLE;
               end
               default: begin
                  st <= ST_IDLE;
               end
            endcase
         end
      end
   end

   assign dio_oe = oe_q;

endmodule

// File: rtl/dwh_checks.sv
`timescale 1ns/1ps
module dwh_checks #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wclk,
   input logic              dio_o,
   input logic              dio_oe,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic              rsp_valid,
   input logic [2:0]        rsp_ack,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              rsp_perr,
   input logic              rsp_proto_err
);

   p_drive_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(dio_o) || !$stable(dio_oe)) |-> $fell(wclk));

   p_ready_line_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (dio_oe && !dio_o));

   p_ready_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> !cmd_ready);

   p_rsp_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   p_perr_only_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_perr) |-> (rsp_ack == 3'b001));

   p_no_data_nonok_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_ack != 3'b001) |-> (rsp_rdata == '0));

   p_proto_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_proto_err) |-> (!rsp_perr && $countones(rsp_ack) != 1));

endmodule

bind dwire_host dwh_checks #(
   .DATA_W (DATA_W)
) i_dwh_checks (
   .clk           (clk),
   .rst_n         (rst_n),
   .wclk          (wclk),
   .dio_o         (dio_o),
   .dio_oe        (dio_oe),
   .cmd_valid     (cmd_valid),
   .cmd_ready     (cmd_ready),
   .rsp_valid     (rsp_valid),
   .rsp_ack       (rsp_ack),
   .rsp_rdata     (rsp_rdata),
   .rsp_perr      (rsp_perr),
   .rsp_proto_err (rsp_proto_err)
);

// File: tb/test_dwire_host.sv
`timescale 1ns/1ps
module test_dwire_host;

   typedef struct packed {
      logic        ap;
      logic        rd;
      logic [1:0]  addr;
      logic [31:0] wdata;
      logic [2:0]  ack;
      logic [31:0] rdata;
      logic        bad_par;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b0, 2'd0, 32'hA5A5_0F0F, 3'b001, 32'h0000_0000, 1'b0},
      '{1'b1, 1'b1, 2'd3, 32'h0000_0000, 3'b001, 32'h1234_5678, 1'b0},
      '{1'b0, 1'b1, 2'd1, 32'h0000_0000, 3'b001, 32'hFFFF_FFFF, 1'b1},
      '{1'b1, 1'b0, 2'd2, 32'h8000_0001, 3'b010, 32'h0000_0000, 1'b0},
      '{1'b0, 1'b1, 2'd2, 32'h0000_0000, 3'b100, 32'hDEAD_BEEF, 1'b0},
      '{1'b1, 1'b0, 2'd1, 32'h1111_2222, 3'b111, 32'h0000_0000, 1'b0},
      '{1'b0, 1'b1, 2'd0, 32'h0000_0000, 3'b001, 32'h0000_0000, 1'b0},
      '{1'b1, 1'b0, 2'd3, 32'h0000_0007, 3'b001, 32'h0000_0000, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  div_i = 8'd3;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic        cmd_ap = 1'b0;
   logic        cmd_rd = 1'b0;
   logic [1:0]  cmd_addr = 2'd0;
   logic [31:0] cmd_wdata = '0;
   logic        rsp_valid;
   logic [2:0]  rsp_ack;
   logic [31:0] rsp_rdata;
   logic        rsp_perr;
   logic        rsp_proto_err;
   logic        wclk;
   logic        dio_o;
   logic        dio_oe;
   logic        dio_i = 1'b1;

   int nchk = 0;
   int nfail = 0;
   int rsp_cnt = 0;
   logic [2:0]  r_ack;
   logic [31:0] r_rdata;
   logic        r_perr;
   logic        r_proto;

   always #10 clk = ~clk;

   dwire_host i_dwire_host (
      .clk           (clk),
      .rst_n         (rst_n),
      .div_i         (div_i),
      .cmd_valid     (cmd_valid),
      .cmd_ready     (cmd_ready),
      .cmd_ap        (cmd_ap),
      .cmd_rd        (cmd_rd),
      .cmd_addr      (cmd_addr),
      .cmd_wdata     (cmd_wdata),
      .rsp_valid     (rsp_valid),
      .rsp_ack       (rsp_ack),
      .rsp_rdata     (rsp_rdata),
      .rsp_perr      (rsp_perr),
      .rsp_proto_err (rsp_proto_err),
      .wclk          (wclk),
      .dio_o         (dio_o),
      .dio_oe        (dio_oe),
      .dio_i         (dio_i)
   );

   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         rsp_cnt = rsp_cnt + 1;
         r_ack   = rsp_ack;
         r_rdata = rsp_rdata;
         r_perr  = rsp_perr;
         r_proto = rsp_proto_err;
      end
   end

   task automatic chk(input bit ok, input string tag,
                      input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic run_vec(input vec_t v);
      logic [7:0]  eh;
      logic [7:0]  gh;
      logic [32:0] gd;
      logic [32:0] ed;
      logic        oe_bad;
      logic        ok;
      logic        e_proto;
      int          base;
      base    = rsp_cnt;
      ok      = (v.ack == 3'b001);
      e_proto = !(v.ack == 3'b001 || v.ack == 3'b010 || v.ack == 3'b100);
      eh      = {1'b1, 1'b0, v.ap ^ v.rd ^ v.addr[0] ^ v.addr[1],
                 v.addr[1], v.addr[0], v.rd, v.ap, 1'b1};

      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1;
      cmd_ap    = v.ap;
      cmd_rd    = v.rd;
      cmd_addr  = v.addr;
      cmd_wdata = v.wdata;
      @(negedge clk);
      cmd_valid = 1'b0;

      // request frame
      do begin
         @(posedge wclk); #1;
      end while (!(dio_oe && dio_o));
      gh[0]  = 1'b1;
      oe_bad = 1'b0;
      for (int i = 1; i < 8; i++) begin
         @(posedge wclk); #1;
         gh[i] = dio_o;
         if (!dio_oe) oe_bad = 1'b1;
      end
      chk(gh == eh && !oe_bad, "R1 request frame", {55'd0, oe_bad, gh}, {56'd0, eh});

      // turnaround then acknowledge
      @(posedge wclk); #1;
      chk(!dio_oe, "R3 line released after request", 64'(dio_oe), 64'd0);
      oe_bad = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge wclk); #1;
         dio_i = v.ack[i];
         @(posedge wclk); #1;
         if (dio_oe) oe_bad = 1'b1;
      end
      chk(!oe_bad, "R3 line released during acknowledge", 64'(oe_bad), 64'd0);

      if (ok && !v.rd) begin
         @(negedge wclk); #1;
         dio_i  = 1'b1;
         oe_bad = 1'b0;
         for (int i = 0; i < 33; i++) begin
            if (i > 0) begin
               @(posedge wclk); #1;
            end else begin
               @(posedge wclk); #1;
            end
            gd[i] = dio_o;
            if (!dio_oe) oe_bad = 1'b1;
         end
         ed = {^v.wdata, v.wdata};
         chk(gd == ed && !oe_bad, "R4 write data and parity", 64'(gd), 64'(ed));
         @(posedge wclk); #1;
         chk(dio_oe && !dio_o && !cmd_ready, "R4 R9 idle low right after write data",
             {61'd0, dio_oe, dio_o, cmd_ready}, 64'h4);
      end else if (ok && v.rd) begin
         oe_bad = 1'b0;
         for (int i = 0; i < 33; i++) begin
            @(negedge wclk); #1;
            dio_i = (i < 32) ? v.rdata[i] : (^v.rdata ^ v.bad_par);
            @(posedge wclk); #1;
            if (dio_oe) oe_bad = 1'b1;
         end
         chk(!oe_bad, "R5 line released during read data", 64'(oe_bad), 64'd0);
         @(negedge wclk); #1;
         dio_i = 1'b1;
         @(posedge wclk); #1;
         chk(!dio_oe, "R5 turnaround after read data", 64'(dio_oe), 64'd0);
         @(posedge wclk); #1;
         chk(dio_oe && !dio_o && !cmd_ready, "R9 idle low after read",
             {61'd0, dio_oe, dio_o, cmd_ready}, 64'h4);
      end else begin
         @(negedge wclk); #1;
         dio_i = 1'b1;
         @(posedge wclk); #1;
         chk(!dio_oe, "R7 turnaround after non-OK acknowledge", 64'(dio_oe), 64'd0);
         @(posedge wclk); #1;
         chk(dio_oe && !dio_o && !cmd_ready, "R7 R9 no data phase, idle low",
             {61'd0, dio_oe, dio_o, cmd_ready}, 64'h4);
      end

      chk(rsp_cnt == base + 1, "R10 one response per command", 64'(rsp_cnt), 64'(base + 1));
      chk(r_ack == v.ack, "R3 acknowledge code", 64'(r_ack), 64'(v.ack));
      chk(r_proto == e_proto, "R8 undefined acknowledge flag", 64'(r_proto), 64'(e_proto));
      chk(r_perr == (ok && v.rd && v.bad_par), "R6 read parity flag",
          64'(r_perr), 64'(ok && v.rd && v.bad_par));
      chk(r_rdata == ((ok && v.rd) ? v.rdata : 32'd0), "R5 R7 returned read data",
          64'(r_rdata), 64'((ok && v.rd) ? v.rdata : 32'd0));
   endtask

   task automatic measure_half(input int exp_clks);
      logic w0;
      int   n;
      @(negedge clk);
      w0 = wclk;
      while (wclk == w0) @(negedge clk);
      w0 = wclk;
      n  = 0;
      while (wclk == w0) begin
         @(negedge clk);
         n++;
      end
      chk(n == exp_clks, "R2 wclk half period", 64'(n), 64'(exp_clks));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired act=%0d exp=done", nchk);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      logic pw;
      int   falls;
      repeat (3) @(negedge clk);
      chk(!cmd_ready && !rsp_valid && dio_oe && !dio_o && !wclk, "R9 reset state",
          {59'd0, cmd_ready, rsp_valid, dio_oe, dio_o, wclk}, 64'h4);
      rst_n = 1'b1;

      // idle falling edges before the first ready
      falls = 0;
      pw    = wclk;
      while (!cmd_ready && falls < 10) begin
         @(negedge clk);
         if (pw && !wclk) falls++;
         pw = wclk;
      end
      chk(falls == 2, "R9 idle falls before ready after reset", 64'(falls), 64'd2);

      measure_half(4);

      for (int k = 0; k < NV; k++) begin
         run_vec(VECS[k]);
      end

      div_i = 8'd5;
      measure_half(6);
      run_vec(VECS[1]);
      run_vec(VECS[7]);
      div_i = 8'd3;
      measure_half(4);

      // no command while busy: a second response never appears unasked
      repeat (40) @(negedge clk);
      chk(rsp_cnt == NV + 2, "R10 response count total", 64'(rsp_cnt), 64'(NV + 2));

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule